// File: doc/BRIEF.md
# Receive Packet Error Discard Filter

This block sits behind a wide receive user data path that delivers up to four 64-bit words per beat. Every beat carries a valid-word count, a start flag, a four-bit end field and an error flag. The block writes each incoming packet into an internal store. It releases the packet downstream only after the end beat has arrived with no error anywhere in the packet. Any packet that carries an error is rolled back out of the store, even when its end field looks well formed. Such a packet never reaches the output, and a one-cycle drop pulse reports it.

The input side has no back-pressure, because the receive link cannot be stalled. If the store fills while a packet is still arriving, that packet is abandoned: its remaining beats are swallowed and it is reported as dropped. The output side is a valid/ready stream. A beat is transferred on a clock edge where both `out_valid` and `out_ready` are high. While `out_ready` is low, the presented beat and its fields hold still. The store holds `DEPTH` beats, and `DEPTH` must be a power of two. On each end beat, the block presents the exact byte length of the packet it delivers.

Top module: `rxf_err_filter`

## Requirements
- R1: Valid words occupy the most significant word slots of a beat, and their number (1 to 4) is given by the 3-bit `in_nwords`. Every beat of a delivered packet leaves the block in the order it arrived, with the same word count, start flag and end flag.
- R2: Bit 3 of `in_eop` marks the final beat of a packet. Bits 2:0 give the number of valid bytes in the last valid word, counted from its most significant byte. The value 0 means all 8 bytes.
- R3: On a delivered end beat, `out_len` equals the packet's byte length: 8 bytes for each valid word before the last one, plus the final-word byte count. On every other beat, `out_len` is 0.
- R4: An error flag on any beat of a packet, including its end beat, removes the whole packet. No beat of that packet is output, and `pkt_dropped` is high for exactly one cycle after the end beat is taken.
- R5: Cycles with `in_valid` low change nothing: the buffered state stays as it was and no drop is reported.
- R6: No beat of a packet is presented at the output until that packet's clean end beat has been taken (store and forward).
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the presented data and length do not change.
- R8: If a beat arrives while the store holds `DEPTH` beats, the rest of that packet is discarded up to and including its end beat, and it is reported on `pkt_dropped`. Packets already released are delivered intact.
- R9: At the output, word slots past the word count are zero. In the last word of an end beat, bytes past the final byte count are zero.
- R10: After reset, `out_valid` and `pkt_dropped` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present (no back-pressure) |
| in_data | input | 256 | Input words, slot 0 in the top 64 bits |
| in_nwords | input | 3 | Number of valid words in the beat |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 4 | Bit 3 end flag, bits 2:0 final-word byte count |
| in_err | input | 1 | Packet carries an error |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 256 | Output words with invalid bytes zeroed |
| out_nwords | output | 3 | Number of valid words in the output beat |
| out_sop | output | 1 | First beat of a delivered packet |
| out_eop | output | 1 | Final beat of a delivered packet |
| out_last_bytes | output | 3 | Final-word byte count (0 means 8) |
| out_len | output | 16 | Packet byte length on the end beat, else 0 |
| pkt_dropped | output | 1 | One-cycle pulse per discarded packet |

## Verification
The checker watches the pointer relations on every cycle. The write pointer never runs more than the store depth ahead of the read pointer, and the committed point never passes the write point. It also checks that a stalled output beat holds still, that an errored end beat leaves the commit point unchanged and raises the drop pulse, and that idle input cycles leave the write side alone. Only the bench's packet scenarios can show the data-level results. These are exact byte lengths, including a final byte count of zero, zeroed bytes past the packet end, a packet dropped because of an error on its first beat rather than its end beat, and the recovery after an overflow mid-packet with the earlier packets delivered unharmed.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int CNT_W   = 3;
  localparam int LB_W    = 3;
  localparam int BYTE_W  = 8;

  typedef struct packed {
    logic            sop;
    logic            eop;
    logic [LB_W-1:0] last_bytes;
  } rxf_tag_t;

  typedef enum logic {
    MODE_ACCEPT  = 1'b0,
    MODE_DISCARD = 1'b1
  } rxf_mode_e;

  function automatic logic [3:0] eff_bytes(input logic [LB_W-1:0] lb);
    return (lb == '0) ? 4'd8 : {1'b0, lb};
  endfunction
endpackage

// File: rtl/rxf_beat_mask.sv
module rxf_beat_mask
  import rxf_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int WORD_W = 64,
  parameter int LEN_W  = 16,
  localparam int DATA_W     = WORDS * WORD_W,
  localparam int WORD_BYTES = WORD_W / BYTE_W
) (
  input  logic [DATA_W-1:0] data_in,
  input  logic [CNT_W-1:0]  nwords,
  input  logic              eop,
  input  logic [LB_W-1:0]   last_bytes,
  output logic [DATA_W-1:0] data_out,
  output logic [LEN_W-1:0]  beat_bytes
);
  logic [3:0] tail_bytes;
  assign tail_bytes = eff_bytes(last_bytes);

  // Slot 0 is the most significant word; byte 0 is the top byte of a word.
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
      logic keep;
      assign keep = (CNT_W'(w) < nwords) &&
                    !(eop && (CNT_W'(w) == nwords - 1'b1) && (4'(b) >= tail_bytes));
      assign data_out[DATA_W-1-w*WORD_W-b*BYTE_W -: BYTE_W] =
        keep ? data_in[DATA_W-1-w*WORD_W-b*BYTE_W -: BYTE_W] : '0;
    end
  end

  always_comb begin
    if (eop)
      beat_bytes = LEN_W'(nwords - 1'b1) * LEN_W'(WORD_BYTES) + LEN_W'(tail_bytes);
    else
      beat_bytes = LEN_W'(nwords) * LEN_W'(WORD_BYTES);
  end
endmodule

// File: rtl/rxf_ingress_ctrl.sv
module rxf_ingress_ctrl
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic             in_err,
  input  logic [LEN_W-1:0] beat_bytes,
  input  logic [PTR_W:0]   rd_ptr,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [LEN_W-1:0] wr_len,
  output logic [PTR_W:0]   wr_ptr,
  output logic [PTR_W:0]   commit_ptr,
  output logic             pkt_dropped
);
  rxf_mode_e        mode;
  logic             err_seen;
  logic [LEN_W-1:0] acc;
  logic [PTR_W:0]   used;
  logic             room, err_now, accept, bad_end;
  logic [LEN_W-1:0] run_len;

  always_comb begin
    used    = wr_ptr - rd_ptr;
    room    = used < (PTR_W+1)'(DEPTH);
    err_now = in_err | err_seen;
    run_len = (in_sop ? '0 : acc) + beat_bytes;
    accept  = in_valid && (mode == MODE_ACCEPT);
    bad_end = accept && in_eop && err_now;
    wr_en   = accept && !bad_end && room;
    wr_addr = wr_ptr[PTR_W-1:0];
    wr_len  = in_eop ? run_len : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= MODE_ACCEPT;
      err_seen    <= 1'b0;
      acc         <= '0;
      wr_ptr      <= '0;
      commit_ptr  <= '0;
      pkt_dropped <= 1'b0;
    end else begin
      pkt_dropped <= 1'b0;
      if (in_valid) begin
        if (mode == MODE_DISCARD) begin
          if (in_eop) begin
            mode        <= MODE_ACCEPT;
            pkt_dropped <= 1'b1;
          end
        end else if (bad_end) begin
          wr_ptr      <= commit_ptr;
          err_seen    <= 1'b0;
          acc         <= '0;
          pkt_dropped <= 1'b1;
        end else if (!room) begin
          wr_ptr   <= commit_ptr;
          err_seen <= 1'b0;
          acc      <= '0;
          if (in_eop) pkt_dropped <= 1'b1;
          else        mode        <= MODE_DISCARD;
        end else begin
          wr_ptr <= wr_ptr + 1'b1;
          if (in_eop) begin
            commit_ptr <= wr_ptr + 1'b1;
            err_seen   <= 1'b0;
            acc        <= '0;
          end else begin
            err_seen <= err_now;
            acc      <= run_len;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rxf_pkt_store.sv
module rxf_pkt_store
  import rxf_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  wr_nwords,
  input  rxf_tag_t          wr_tag,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [PTR_W:0]    commit_ptr,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  out_nwords,
  output rxf_tag_t          out_tag,
  output logic [LEN_W-1:0]  out_len,
  output logic [PTR_W:0]    rd_ptr
);
  logic [DATA_W-1:0] mem_data [DEPTH];
  logic [CNT_W-1:0]  mem_nw   [DEPTH];
  rxf_tag_t          mem_tag  [DEPTH];
  logic [LEN_W-1:0]  mem_len  [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_data[wr_addr] <= wr_data;
      mem_nw[wr_addr]   <= wr_nwords;
      mem_tag[wr_addr]  <= wr_tag;
      mem_len[wr_addr]  <= wr_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rd_ptr <= '0;
    else if (out_valid && out_ready) rd_ptr <= rd_ptr + 1'b1;
  end

  always_comb begin
    out_valid  = (rd_ptr != commit_ptr);
    out_data   = mem_data[rd_ptr[PTR_W-1:0]];
    out_nwords = mem_nw[rd_ptr[PTR_W-1:0]];
    out_tag    = mem_tag[rd_ptr[PTR_W-1:0]];
    out_len    = mem_len[rd_ptr[PTR_W-1:0]];
  end
endmodule

// File: rtl/rxf_err_filter.sv
module rxf_err_filter
  import rxf_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int WORD_W = 64,
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 16,
  localparam int DATA_W = WORDS * WORD_W,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [2:0]        in_nwords,
  input  logic              in_sop,
  input  logic [3:0]        in_eop,
  input  logic              in_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [2:0]        out_nwords,
  output logic              out_sop,
  output logic              out_eop,
  output logic [2:0]        out_last_bytes,
  output logic [LEN_W-1:0]  out_len,
  output logic              pkt_dropped
);
  logic [DATA_W-1:0] masked;
  logic [LEN_W-1:0]  beat_bytes, wr_len;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr;
  logic [PTR_W:0]    wr_ptr, commit_ptr, rd_ptr;
  rxf_tag_t          in_tag, out_tag;

  assign in_tag = '{sop: in_sop, eop: in_eop[3], last_bytes: in_eop[2:0]};

  rxf_beat_mask #(.WORDS(WORDS), .WORD_W(WORD_W), .LEN_W(LEN_W)) mask_i (
    .data_in    (in_data),
    .nwords     (in_nwords),
    .eop        (in_eop[3]),
    .last_bytes (in_eop[2:0]),
    .data_out   (masked),
    .beat_bytes (beat_bytes)
  );

  rxf_ingress_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sop      (in_sop),
    .in_eop      (in_eop[3]),
    .in_err      (in_err),
    .beat_bytes  (beat_bytes),
    .rd_ptr      (rd_ptr),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_len      (wr_len),
    .wr_ptr      (wr_ptr),
    .commit_ptr  (commit_ptr),
    .pkt_dropped (pkt_dropped)
  );

  rxf_pkt_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (masked),
    .wr_nwords  (in_nwords),
    .wr_tag     (in_tag),
    .wr_len     (wr_len),
    .commit_ptr (commit_ptr),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_nwords (out_nwords),
    .out_tag    (out_tag),
    .out_len    (out_len),
    .rd_ptr     (rd_ptr)
  );

  assign out_sop        = out_tag.sop;
  assign out_eop        = out_tag.eop;
  assign out_last_bytes = out_tag.last_bytes;
endmodule

// File: rtl/rxf_err_filter_chk.sv
module rxf_err_filter_chk #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 256,
  parameter int LEN_W  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_eop_flag,
  input logic              in_err,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [LEN_W-1:0]  out_len,
  input logic              pkt_dropped,
  input logic [PTR_W:0]    wr_ptr,
  input logic [PTR_W:0]    commit_ptr,
  input logic [PTR_W:0]    rd_ptr
);
  logic [PTR_W:0] fill_w, fill_c;
  assign fill_w = wr_ptr - rd_ptr;
  assign fill_c = commit_ptr - rd_ptr;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_w <= (PTR_W+1)'(DEPTH)); // R8

  AST_COMMIT_BEHIND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_c <= fill_w); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_len)); // R7

  AST_ERR_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_eop_flag && in_err |=> pkt_dropped && $stable(commit_ptr)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !pkt_dropped && $stable(wr_ptr)); // R5
endmodule

bind rxf_err_filter rxf_err_filter_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LEN_W(LEN_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_eop_flag (in_eop[3]),
  .in_err      (in_err),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_len     (out_len),
  .pkt_dropped (pkt_dropped),
  .wr_ptr      (wr_ptr),
  .commit_ptr  (commit_ptr),
  .rd_ptr      (rd_ptr)
);

// File: tb/rxf_err_filter_tb_top.sv
module rxf_err_filter_tb_top;
  localparam int WORDS  = 4;
  localparam int DATA_W = 256;
  localparam int LEN_W  = 16;
  localparam int NVEC   = 8;
  // {tag, full beats, last-beat words, last bytes, err pos (0 none,1 end,2 first), idle, delivered, length}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd1, 4'd2, 3'd3, 3'd3, 2'd1, 3'd2, 1'b0, 8'd83},
    {8'd2, 4'd2, 3'd2, 3'd3, 2'd0, 3'd1, 1'b1, 8'd75},
    {8'd3, 4'd0, 3'd1, 3'd0, 2'd0, 3'd0, 1'b1, 8'd8},
    {8'd4, 4'd1, 3'd4, 3'd5, 2'd0, 3'd0, 1'b1, 8'd61},
    {8'd5, 4'd0, 3'd2, 3'd1, 2'd1, 3'd1, 1'b0, 8'd9},
    {8'd6, 4'd3, 3'd1, 3'd7, 2'd0, 3'd0, 1'b1, 8'd103},
    {8'd7, 4'd2, 3'd1, 3'd2, 2'd2, 3'd1, 1'b0, 8'd66},
    {8'd8, 4'd0, 3'd4, 3'd0, 2'd0, 3'd2, 1'b1, 8'd32}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic [2:0]        in_nwords = '0;
  logic              in_sop = 1'b0;
  logic [3:0]        in_eop = '0;
  logic              in_err = 1'b0;
  logic              out_valid, out_ready;
  logic [DATA_W-1:0] out_data;
  logic [2:0]        out_nwords, out_last_bytes;
  logic              out_sop, out_eop, pkt_dropped;
  logic [LEN_W-1:0]  out_len;

  int n_checks = 0, n_fail = 0;
  int exp_tag [64], exp_len [64], exp_n = 0, exp_drops = 0;
  int rx_tag [64], rx_len [64], rx_olen [64], rx_n = 0, drops_seen = 0;
  int cur_tag = 0, cur_bytes = 0;

  always #5 clk = ~clk;

  rxf_err_filter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_nwords(in_nwords), .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_nwords(out_nwords), .out_sop(out_sop), .out_eop(out_eop),
    .out_last_bytes(out_last_bytes), .out_len(out_len), .pkt_dropped(pkt_dropped)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_beat(input int tag, input int nw, input bit sop, input bit eop,
                            input int lb, input bit err);
    in_valid  = 1'b1;
    in_data   = {32{8'(tag)}};
    in_nwords = 3'(nw);
    in_sop    = sop;
    in_eop    = {eop, 3'(lb)};
    in_err    = err;
    @(posedge clk); #2;
    in_valid  = 1'b0;
    in_err    = 1'b0;
  endtask

  task automatic send_pkt(input int tag, input int full, input int lw, input int lb, input int errpos);
    for (int i = 0; i <= full; i++) begin
      drive_beat(tag, (i < full) ? WORDS : lw, i == 0, i == full, (i == full) ? lb : 0,
                 (errpos == 1 && i == full) || (errpos == 2 && i == 0));
    end
  endtask

  // Output monitor, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (pkt_dropped) drops_seen++;
      if (out_valid && out_ready) begin
        int lbe, nb;
        bit ok;
        if (out_sop) begin
          cur_tag   = int'(out_data[DATA_W-1 -: 8]);
          cur_bytes = 0;
        end
        lbe = (out_last_bytes == 0) ? 8 : int'(out_last_bytes);
        ok = 1'b1;
        nb = 0;
        for (int w = 0; w < WORDS; w++) begin
          for (int b = 0; b < 8; b++) begin
            bit vld;
            logic [7:0] by;
            vld = (w < int'(out_nwords)) && !(out_eop && w == int'(out_nwords) - 1 && b >= lbe);
            by  = out_data[DATA_W-1-w*64-b*8 -: 8];
            if (vld) begin
              nb++;
              if (int'(by) != cur_tag) ok = 1'b0;
            end else if (by != 8'h00) ok = 1'b0;
          end
        end
        chk(ok, "R9 masked bytes", ok, 1);
        cur_bytes += nb;
        if (out_eop) begin
          rx_tag[rx_n]  = cur_tag;
          rx_len[rx_n]  = cur_bytes;
          rx_olen[rx_n] = int'(out_len);
          rx_n++;
        end else begin
          chk(out_len == 0, "R3 len zero off end beat", out_len, 0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] held;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk(!out_valid, "R10 out_valid after reset", out_valid, 0);
    chk(!pkt_dropped, "R10 pkt_dropped after reset", pkt_dropped, 0);
    rst_n = 1'b1;
    @(posedge clk); #2;

    // Vector table: R1 R2 R3 R4
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      v = VEC[i];
      send_pkt(int'(v[31:24]), int'(v[23:20]), int'(v[19:17]), int'(v[16:14]), int'(v[13:12]));
      if (v[8]) begin
        exp_tag[exp_n] = int'(v[31:24]);
        exp_len[exp_n] = int'(v[7:0]);
        exp_n++;
      end else exp_drops++;
      repeat (int'(v[11:9])) begin @(posedge clk); #2; end
    end
    repeat (10) begin @(posedge clk); #2; end

    // R5: idle cycles leave the empty block quiet
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2;
      chk(!out_valid && !pkt_dropped, "R5 idle quiet", {out_valid, pkt_dropped}, 0);
    end

    // R6: nothing appears before the clean end beat
    drive_beat(30, WORDS, 1'b1, 1'b0, 0, 1'b0);
    chk(!out_valid, "R6 partial packet hidden", out_valid, 0);
    drive_beat(30, 2, 1'b0, 1'b1, 4, 1'b0);
    chk(out_valid, "R6 visible after end beat", out_valid, 1);
    exp_tag[exp_n] = 30; exp_len[exp_n] = 44; exp_n++;
    repeat (6) begin @(posedge clk); #2; end

    // R7 and R8: stall output, fill store, overflow a packet
    out_ready = 1'b0;
    for (int t = 20; t < 23; t++) begin
      send_pkt(t, 3, 4, 0, 0);
      exp_tag[exp_n] = t; exp_len[exp_n] = 128; exp_n++;
    end
    held = out_data;
    repeat (3) begin @(posedge clk); #2; end
    chk(out_valid && out_data == held, "R7 stalled beat holds", out_valid, 1);
    chk(int'(out_data[DATA_W-1 -: 8]) == 20 && out_sop, "R7 head beat", out_data[DATA_W-1 -: 8], 20);
    send_pkt(23, 5, 1, 1, 0);
    exp_drops++;
    @(posedge clk); #2;
    out_ready = 1'b1;
    repeat (30) begin @(posedge clk); #2; end

    // Ordered comparison of delivered packets
    chk(rx_n == exp_n, "R1 delivered packet count", rx_n, exp_n);
    for (int i = 0; i < exp_n && i < rx_n; i++) begin
      chk(rx_tag[i] == exp_tag[i], "R1 delivered order", rx_tag[i], exp_tag[i]);
      chk(rx_len[i] == exp_len[i], "R2 byte count from fields", rx_len[i], exp_len[i]);
      chk(rx_olen[i] == exp_len[i], "R3 reported length", rx_olen[i], exp_len[i]);
    end
    chk(drops_seen == exp_drops, "R4 R8 drop pulses", drops_seen, exp_drops);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule